// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block turns a programmed mode word and a starting column into the column address sequence for one SDRAM read or write burst. The controller pulses `start` together with the mode word, the read/write direction and the first column. From the next clock on, the block puts out one column per cycle with `col_valid`. It raises `col_last` on the final column of a fixed-length burst.

The burst span is aligned. For a length of 2, 4 or 8, the column bits above the span stay fixed and only the low bits move. In sequential order the low bits count upward and wrap inside the span. In interleaved order they are the starting offset XORed with a running count. A full-row burst walks all 1,024 columns with wrap-around and runs until `stop` ends it. A write-single mode bit limits writes to one column while reads keep the programmed length. Reserved or unsupported settings raise `mode_err` and are issued as a single column.

Top module: `burst_colgen`

## Requirements
- R1: While `rst_n` is low, and after it goes high until the first `start`, `col_valid`, `col_last` and `mode_err` are 0.
- R2: A `start` sampled on a clock edge makes `col_valid` 1 and `col_addr` equal to `start_col` after that edge. Each later column follows one clock after the previous one.
- R3: The length code in mode bits [2:0] gives the number of columns: 000 gives 1, 001 gives 2, 010 gives 4 and 011 gives 8. `col_last` is 1 only with the final column, and `col_valid` is 0 on the clock after it unless a new `start` is sampled.
- R4: In sequential order (mode bit 3 = 0) with length L, column i is `start_col` with its low log2(L) bits replaced by (start offset + i) mod L. The upper bits are unchanged.
- R5: In interleaved order (mode bit 3 = 1) with length L, column i is `start_col` with its low log2(L) bits replaced by (start offset XOR i). The upper bits are unchanged.
- R6: Code 111 with mode bit 3 = 0 is a full-row burst. Column i is (`start_col` + i) mod 1024, `col_last` stays 0, and the burst continues until `stop`.
- R7: With code 000, mode bit 3 has no effect: exactly one column, equal to `start_col`, is issued with `col_last` = 1 and `mode_err` = 0.
- R8: When mode bit 9 is 1 and `is_write` is 1, exactly one column is issued. When `is_write` is 0, the programmed length applies.
- R9: Codes 100, 101 and 110, and code 111 with mode bit 3 = 1, set `mode_err` to 1 from the clock after `start` until the next `start`. Such a burst issues one column with `col_last` = 1.
- R10: A `stop` sampled while `col_valid` is 1 makes `col_valid` 0 after that edge. When `start` and `stop` are sampled together, the new burst begins.
- R11: A `start` sampled during a burst abandons the old one, and the new sequence begins after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_word | input | 13 | Programmed mode word, sampled with `start` |
| start | input | 1 | Begin a burst with the presented settings |
| is_write | input | 1 | 1 for a write burst, 0 for a read burst |
| start_col | input | 10 | First column of the burst |
| stop | input | 1 | Terminate the running burst |
| col_addr | output | 10 | Current column address |
| col_valid | output | 1 | `col_addr` holds a column of the burst |
| col_last | output | 1 | Final column of a fixed-length burst |
| mode_err | output | 1 | Settings of the latest burst were reserved or unsupported |

## Verification
Every output is one register stage from its cause. The first column and `mode_err` are due on the edge that samples `start`. Each further column is due one edge after the one before it. The drop of `col_valid` after the last column, after `stop`, or the change to a new sequence after a restart is due one edge after it is caused. The bench changes inputs on the falling edge and reads outputs on the next falling edge, so each read sees exactly one rising edge of progress. A burst of L columns is then checked on L consecutive falling edges, plus one more for the idle state.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

    // Decoded burst settings carried from the decoder to the sequencer
    typedef struct packed {
        logic [1:0] len_log;  // log2 of fixed burst length (0..3)
        logic       full;     // full-row burst, ends only on stop
        logic       ilv;      // XOR ordering instead of counting
        logic       err;      // reserved or unsupported setting
    } burst_cfg_t;

    // Length field codes; their values are decoded by the neighbour
    typedef enum logic [2:0] {
        LEN_ONE   = 3'b000,
        LEN_TWO   = 3'b001,
        LEN_FOUR  = 3'b010,
        LEN_EIGHT = 3'b011,
        LEN_ROW   = 3'b111
    } len_code_e;

endpackage

// File: rtl/colgen_mode_dec.sv
module colgen_mode_dec
    import colgen_pkg::*;
#(
    parameter int MODE_W  = 13,
    parameter int ORD_POS = 3,
    parameter int WS_POS  = 9
) (
    input  logic [MODE_W-1:0] mode_word,
    input  logic              is_write,
    output burst_cfg_t        cfg
);

    localparam logic [MODE_W-1:0] USED_MASK =
        MODE_W'(7) | (MODE_W'(1) << ORD_POS) | (MODE_W'(1) << WS_POS);

    logic [2:0] len_code;
    logic       ord_bit;
    logic       single_wr;
    logic       unused_mode_bits;

    assign len_code         = mode_word[2:0];
    assign ord_bit          = mode_word[ORD_POS];
    assign single_wr        = is_write & mode_word[WS_POS];
    assign unused_mode_bits = ^(mode_word & ~USED_MASK);

    always_comb begin
        cfg = '0;
        case (len_code)
            LEN_ONE:   cfg.len_log = 2'd0;
            LEN_TWO:   cfg.len_log = 2'd1;
            LEN_FOUR:  cfg.len_log = 2'd2;
            LEN_EIGHT: cfg.len_log = 2'd3;
            LEN_ROW: begin
                if (ord_bit) cfg.err  = 1'b1;
                else         cfg.full = 1'b1;
            end
            default:   cfg.err = 1'b1;
        endcase
        // ordering only matters for multi-column fixed bursts
        cfg.ilv = ord_bit & (cfg.len_log != 2'd0);
        if (single_wr) begin
            cfg.len_log = 2'd0;
            cfg.full    = 1'b0;
            cfg.ilv     = 1'b0;
        end
    end

endmodule

// File: rtl/colgen_addr.sv
module colgen_addr
    import colgen_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  burst_cfg_t        cfg,
    input  logic [COL_W-1:0]  base_col,
    input  logic [COL_W-1:0]  idx,
    output logic [COL_W-1:0]  col
);

    logic [COL_W-1:0] span_mask;
    logic [COL_W-1:0] counted;
    logic [COL_W-1:0] mixed;
    logic [COL_W-1:0] moving;

    always_comb begin
        span_mask = cfg.full ? {COL_W{1'b1}} : ~({COL_W{1'b1}} << cfg.len_log);
        counted   = base_col + idx;
        mixed     = base_col ^ idx;
        moving    = cfg.ilv ? mixed : counted;
    end

    // bits inside the span move, bits above it stay with the start column
    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        assign col[b] = span_mask[b] ? moving[b] : base_col[b];
    end

endmodule

// File: rtl/colgen_seq.sv
module colgen_seq
    import colgen_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              stop,
    input  logic [COL_W-1:0]  start_col,
    input  burst_cfg_t        cfg_in,
    output logic [COL_W-1:0]  col,
    output logic              valid,
    output logic              last,
    output logic              err
);

    typedef struct packed {
        logic              valid;
        logic              last;
        logic              err;
        logic [COL_W-1:0]  idx;
        logic [COL_W-1:0]  base;
        burst_cfg_t        cfg;
        logic [COL_W-1:0]  col;
    } seq_state_t;

    seq_state_t       st_d, st_q;
    burst_cfg_t       gen_cfg;
    logic [COL_W-1:0] gen_base;
    logic [COL_W-1:0] gen_idx;
    logic [COL_W-1:0] gen_col;
    logic             advance;
    logic [COL_W-1:0] final_idx;

    // a new burst asks for its index 0, a running one for the next index
    always_comb begin
        gen_cfg  = start ? cfg_in    : st_q.cfg;
        gen_base = start ? start_col : st_q.base;
        gen_idx  = start ? '0        : st_q.idx + 1'b1;
    end

    colgen_addr #(.COL_W(COL_W)) u_addr (
        .cfg      (gen_cfg),
        .base_col (gen_base),
        .idx      (gen_idx),
        .col      (gen_col)
    );

    always_comb begin
        st_d    = st_q;
        advance = 1'b0;
        if (start) begin
            st_d.valid = 1'b1;
            st_d.idx   = '0;
            st_d.base  = start_col;
            st_d.cfg   = cfg_in;
            st_d.err   = cfg_in.err;
            st_d.col   = gen_col;
        end else if (st_q.valid && (stop || st_q.last)) begin
            st_d.valid = 1'b0;
        end else if (st_q.valid) begin
            advance    = 1'b1;
            st_d.idx   = gen_idx;
            st_d.col   = gen_col;
        end
        final_idx = ~({COL_W{1'b1}} << st_d.cfg.len_log);
        st_d.last = st_d.valid && !st_d.cfg.full && (st_d.idx == final_idx);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign col   = st_q.col;
    assign valid = st_q.valid;
    assign last  = st_q.last;
    assign err   = st_q.err;

    p_first_col_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> valid && col == $past(start_col));

    p_last_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
        valid && last && !start |=> !valid);

    p_last_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        last |-> valid);

    p_row_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid && st_q.cfg.full && !stop && !start
        |=> valid && !last && col == COL_W'($past(col) + 1'b1));

    p_err_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start && cfg_in.err |=> valid && last && err);

    p_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        valid && stop && !start |=> !valid);

    p_step_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> valid && $changed(st_q.idx));

endmodule

// File: rtl/burst_colgen.sv
module burst_colgen
    import colgen_pkg::*;
#(
    parameter int COL_W   = 10,
    parameter int MODE_W  = 13,
    parameter int ORD_POS = 3,
    parameter int WS_POS  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_word,
    input  logic              start,
    input  logic              is_write,
    input  logic [COL_W-1:0]  start_col,
    input  logic              stop,
    output logic [COL_W-1:0]  col_addr,
    output logic              col_valid,
    output logic              col_last,
    output logic              mode_err
);

    burst_cfg_t dec_cfg;

    colgen_mode_dec #(
        .MODE_W  (MODE_W),
        .ORD_POS (ORD_POS),
        .WS_POS  (WS_POS)
    ) u_dec (
        .mode_word (mode_word),
        .is_write  (is_write),
        .cfg       (dec_cfg)
    );

    colgen_seq #(.COL_W(COL_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .stop      (stop),
        .start_col (start_col),
        .cfg_in    (dec_cfg),
        .col       (col_addr),
        .valid     (col_valid),
        .last      (col_last),
        .err       (mode_err)
    );

    p_idle_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_err) |-> $past(start));

endmodule

// File: tb/sim_burst_colgen.sv
module sim_burst_colgen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] mode_word = '0;
    logic        start = 1'b0;
    logic        is_write = 1'b0;
    logic [9:0]  start_col = '0;
    logic        stop = 1'b0;
    logic [9:0]  col_addr;
    logic        col_valid, col_last, mode_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    burst_colgen u0 (
        .clk(clk), .rst_n(rst_n), .mode_word(mode_word), .start(start),
        .is_write(is_write), .start_col(start_col), .stop(stop),
        .col_addr(col_addr), .col_valid(col_valid), .col_last(col_last),
        .mode_err(mode_err)
    );

    // 0 means a full-row burst of unbounded length
    function automatic int exp_len(logic [12:0] m, bit wr);
        if (wr && m[9]) return 1;
        case (m[2:0])
            3'd0: return 1;
            3'd1: return 2;
            3'd2: return 4;
            3'd3: return 8;
            3'd7: return m[3] ? 1 : 0;
            default: return 1;
        endcase
    endfunction

    function automatic bit exp_err(logic [12:0] m);
        return (m[2:0] inside {3'd4, 3'd5, 3'd6}) || (m[2:0] == 3'd7 && m[3]);
    endfunction

    function automatic int exp_col(int sc, int i, logic [12:0] m, bit wr);
        int len = exp_len(m, wr);
        int off;
        if (len == 0) return (sc + i) % 1024;
        if (len == 1) return sc;
        off = sc % len;
        off = m[3] ? (off ^ (i % len)) : ((off + i) % len);
        return sc - (sc % len) + off;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // issue one burst; stop_at = column index at which stop is raised (-1: none)
    task automatic burst(logic [12:0] m, bit wr, logic [9:0] sc, int stop_at, string req);
        int len = exp_len(m, wr);
        int n = (len == 0) ? stop_at + 1 : len;
        if (stop_at >= 0 && stop_at < n) n = stop_at + 1;
        @(negedge clk);
        mode_word = m; is_write = wr; start_col = sc; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(mode_err == exp_err(m), "R9", "mode_err", int'(mode_err), int'(exp_err(m)));
        for (int i = 0; i < n; i++) begin
            if (i > 0) @(negedge clk);
            chk(col_valid == 1'b1, req, "col_valid in burst", int'(col_valid), 1);
            chk(int'(col_addr) == exp_col(sc, i, m, wr), req, "col_addr",
                int'(col_addr), exp_col(sc, i, m, wr));
            chk(col_last == (len != 0 && i == len - 1), req, "col_last",
                int'(col_last), int'(len != 0 && i == len - 1));
            if (i == stop_at) stop = 1'b1;
        end
        @(negedge clk);
        stop = 1'b0;
        chk(col_valid == 1'b0, (stop_at >= 0 && stop_at < n) ? "R10" : "R3",
            "col_valid after burst", int'(col_valid), 0);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R2 watchdog: actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed_set;
        seed_set = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        chk(col_valid == 0 && col_last == 0 && mode_err == 0, "R1", "reset outputs",
            int'({col_valid, col_last, mode_err}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(col_valid == 0 && col_last == 0 && mode_err == 0, "R1", "idle after reset",
            int'({col_valid, col_last, mode_err}), 0);

        // directed corner cases
        burst(13'h003, 1'b0, 10'd5,   -1, "R4");   // sequential 8 from 5
        burst(13'h00B, 1'b0, 10'd5,   -1, "R5");   // interleaved 8 from 5
        burst(13'h00A, 1'b0, 10'd102, -1, "R5");   // interleaved 4, upper bits kept
        burst(13'h001, 1'b0, 10'd77,  -1, "R4");   // sequential 2 from odd column
        burst(13'h008, 1'b0, 10'd300, -1, "R7");   // length 1, order bit set
        burst(13'h203, 1'b1, 10'd44,  -1, "R8");   // single-location write
        burst(13'h203, 1'b0, 10'd44,  -1, "R8");   // read keeps length 8
        burst(13'h005, 1'b0, 10'd9,   -1, "R9");   // reserved code
        burst(13'h00F, 1'b0, 10'd9,   -1, "R9");   // full row with interleave
        burst(13'h007, 1'b0, 10'd1020, 7, "R6");   // full row wrapping past 1023
        burst(13'h003, 1'b0, 10'd16,   3, "R10");  // stop inside fixed burst

        // restart during a burst, with stop raised in the same cycle
        @(negedge clk);
        mode_word = 13'h003; is_write = 1'b0; start_col = 10'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(int'(col_addr) == 0, "R11", "first col of old burst", int'(col_addr), 0);
        @(negedge clk);
        start_col = 10'd20; start = 1'b1; stop = 1'b1;
        @(negedge clk);
        start = 1'b0; stop = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (i > 0) @(negedge clk);
            chk(col_valid == 1'b1, "R10", "valid after start with stop", int'(col_valid), 1);
            chk(int'(col_addr) == exp_col(20, i, 13'h003, 1'b0), "R11", "restart col",
                int'(col_addr), exp_col(20, i, 13'h003, 1'b0));
        end
        @(negedge clk);
        chk(col_valid == 1'b0, "R3", "idle after restarted burst", int'(col_valid), 0);

        // constrained random bursts
        for (int k = 0; k < 300; k++) begin
            logic [12:0] m;
            int pick, st;
            m = 13'($urandom());
            pick = int'($urandom_range(0, 9));
            case (pick)
                0, 1:    m[2:0] = 3'd3;
                2, 3:    m[2:0] = 3'd2;
                4:       m[2:0] = 3'd1;
                5:       m[2:0] = 3'd0;
                6, 7:    m[2:0] = 3'd7;
                default: m[2:0] = 3'($urandom_range(4, 6));
            endcase
            st = (m[2:0] == 3'd7 && !m[3]) ? int'($urandom_range(0, 40))
                 : (($urandom_range(0, 4) == 0) ? int'($urandom_range(0, 7)) : -1);
            burst(m, 1'($urandom()), 10'($urandom()), st,
                  m[3] ? "R5" : ((m[2:0] == 3'd7) ? "R6" : "R4"));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule